// File: doc/BRIEF.md
# Timing-Error Detecting Pipeline Stage

This block is a pipeline register stage that tolerates late-arriving data rather than relying on a worst-case timing margin. A main strobe loads the incoming word into the stage's output register. A programmable number of fast-clock ticks later, the stage samples the same input a second time, as a shadow sample. If the shadow sample disagrees with the word taken at the main strobe, the stage treats the difference as a delay fault.

On a delay fault the stage does four things. It replaces its output with the later, correct value. It raises an error flag and a pipeline flush request for one cycle. It holds a slow-mode request high for a programmable number of cycles, so that the clock source can replay the work at a longer period. It also counts the fault in a saturating counter.

The datapath that feeds the stage and the clock generator sit outside the block. Everything inside is clocked by one fast clock, and the main strobe marks the pipeline's working edge.

Top module: `tedp_stage`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `q_out`, `err_out`, `flush_req`, `slow_req` and `fault_cnt` are all zero.
- R2: At a clock edge where `main_stb` is 1, the main sample takes `d_in` and `q_out` shows that value from the next cycle on. Without a strobe or a fault, `q_out` holds its value.
- R3: The shadow sample is taken at the k-th rising edge after the main-strobe edge, where k is `shadow_ticks` as sampled at the strobe, and a value of 0 is treated as 1. If `d_in` at that edge differs from the main sample, `err_out` is 1 for exactly the following cycle.
- R4: `flush_req` is 1 in exactly the cycles in which `err_out` is 1.
- R5: On a fault, `q_out` takes the shadow-sample value in the cycle in which `err_out` is raised.
- R6: A fault loads a slow-mode counter with `slow_len`, and `slow_req` is 1 for exactly that many cycles starting in the error cycle. A fault during slow mode restarts the count. A `slow_len` of 0 gives no slow mode.
- R7: `fault_cnt` goes up by one for each fault and holds at 2^CW-1 once it gets there. It never changes without an error in that same cycle.
- R8: A new `main_stb` that comes before the shadow edge abandons the pending comparison and opens a new window from the new strobe.
- R9: A shadow sample equal to the main sample raises no error, leaves `q_out` unchanged and closes the window, so later changes on `d_in` cause no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_stb | input | 1 | Main sample strobe (pipeline working edge) |
| d_in | input | W | Data from the upstream logic |
| shadow_ticks | input | DW | Shadow-sample delay, in clock edges after the strobe |
| slow_len | input | SW | Number of cycles of slow mode after a fault |
| q_out | output | W | Stage output register |
| err_out | output | 1 | One-cycle delay-fault flag |
| flush_req | output | 1 | One-cycle pipeline flush request |
| slow_req | output | 1 | Request to run at the longer clock period |
| fault_cnt | output | CW | Saturating count of detected faults |

## Verification
Most internal state shows up at the ports one cycle after the edge that sets it. The exception is the shadow timer. If its count is wrong, the error and the corrected `q_out` appear at the wrong edge, or never appear. The reference model compares every output on every cycle, so a timer that is off by one edge shows up within the window in which it goes wrong. A wrong slow-mode count shows up when `slow_req` falls too early or too late. A saturation bug shows up as a wrap of `fault_cnt` to zero. A closed window that was not really closed shows up as a spurious error after a matching shadow sample.

// File: rtl/tedp_pkg.sv
package tedp_pkg;
  typedef enum logic {WIN_IDLE = 1'b0, WIN_OPEN = 1'b1} win_e;
endpackage

// File: rtl/tedp_shadow_timer.sv
module tedp_shadow_timer #(
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [DW-1:0] ticks,
  output logic          fire
);
  import tedp_pkg::*;

  win_e          win_q, win_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] start_val;

  assign start_val = (ticks == '0) ? '0 : ticks - 1'b1;
  assign fire      = (win_q == WIN_OPEN) && (cnt_q == '0);

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    if (arm) begin
      win_d = WIN_OPEN;
      cnt_d = start_val;
    end else if (fire) begin
      win_d = WIN_IDLE;
    end else if (win_q == WIN_OPEN) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= WIN_IDLE;
      cnt_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tedp_slow_ctrl.sv
module tedp_slow_ctrl #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] len,
  output logic          slow
);
  logic [SW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = len;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign slow = (cnt_q != '0);
endmodule

// File: rtl/tedp_fault_ctr.sv
module tedp_fault_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en    = inc && (cnt_q != TOP);
  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tedp_stage.sv
module tedp_stage #(
  parameter int W  = 8,
  parameter int DW = 3,
  parameter int SW = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_stb,
  input  logic [W-1:0]  d_in,
  input  logic [DW-1:0] shadow_ticks,
  input  logic [SW-1:0] slow_len,
  output logic [W-1:0]  q_out,
  output logic          err_out,
  output logic          flush_req,
  output logic          slow_req,
  output logic [CW-1:0] fault_cnt
);
  logic [W-1:0] main_q, main_d;
  logic [W-1:0] q_q, q_d;
  logic         err_q, flush_q;
  logic         shd_fire;
  logic         fault;
  logic         q_en;

  tedp_shadow_timer #(.DW(DW)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(main_stb), .ticks(shadow_ticks), .fire(shd_fire)
  );

  // the comparison always uses the main sample held from the earlier strobe
  assign fault = shd_fire && (d_in != main_q);

  tedp_slow_ctrl #(.SW(SW)) u_slow (
    .clk(clk), .rst_n(rst_n), .load(fault), .len(slow_len), .slow(slow_req)
  );

  tedp_fault_ctr #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(fault), .count(fault_cnt)
  );

  // both a main strobe and a fault load the live input, so the two need no ordering
  assign q_en   = main_stb || fault;
  assign q_d    = d_in;
  assign main_d = main_stb ? d_in : main_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q  <= '0;
      q_q     <= '0;
      err_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      main_q  <= main_d;
      if (q_en) q_q <= q_d;
      err_q   <= fault;
      flush_q <= fault;
    end
  end

  assign q_out     = q_q;
  assign err_out   = err_q;
  assign flush_req = flush_q;
endmodule

// File: rtl/tedp_stage_chk.sv
module tedp_stage_chk #(
  parameter int W  = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  d_in,
  input logic [W-1:0]  q_out,
  input logic          err_out,
  input logic          flush_req,
  input logic          slow_req,
  input logic [CW-1:0] fault_cnt
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!err_out && !flush_req && !slow_req && fault_cnt == '0 && q_out == '0);
    end
  end

  assert_flush_tracks_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_out == flush_req);

  assert_fix_from_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_out -> q_out == $past(d_in)));

  assert_slow_starts_on_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_req) |-> err_out);

  assert_count_moves_only_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fault_cnt != $past(fault_cnt)) -> err_out));

  assert_count_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fault_cnt >= $past(fault_cnt));
endmodule

bind tedp_stage tedp_stage_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .d_in(d_in), .q_out(q_out), .err_out(err_out),
  .flush_req(flush_req), .slow_req(slow_req), .fault_cnt(fault_cnt)
);

// File: tb/tedp_stage_test.sv
module tedp_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8, DW = 3, SW = 4, CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          main_stb;
  logic [W-1:0]  d_in;
  logic [DW-1:0] shadow_ticks;
  logic [SW-1:0] slow_len;
  logic [W-1:0]  q_out;
  logic          err_out, flush_req, slow_req;
  logic [CW-1:0] fault_cnt;

  int checks = 0, errors = 0;

  // reference model state
  int m_main = 0, m_q = 0, m_pend = 0, m_cnt = 0;
  int m_err = 0, m_slow = 0, m_fc = 0;

  tedp_stage #(.W(W), .DW(DW), .SW(SW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .main_stb(main_stb), .d_in(d_in),
    .shadow_ticks(shadow_ticks), .slow_len(slow_len), .q_out(q_out),
    .err_out(err_out), .flush_req(flush_req), .slow_req(slow_req), .fault_cnt(fault_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_main = 0; m_q = 0; m_pend = 0; m_cnt = 0; m_err = 0; m_slow = 0; m_fc = 0;
    end else begin
      int due, flt;
      due = (m_pend != 0) && (m_cnt == 0);
      flt = due && (int'(d_in) != m_main);
      if (main_stb) begin
        m_main = int'(d_in);
        m_q    = int'(d_in);
        m_pend = 1;
        m_cnt  = (shadow_ticks == 0) ? 0 : int'(shadow_ticks) - 1;
      end else if (due) begin
        m_pend = 0;
      end else if (m_pend != 0) begin
        m_cnt = m_cnt - 1;
      end
      if (flt) m_q = int'(d_in);
      m_err = flt;
      if (flt) m_slow = int'(slow_len);
      else if (m_slow > 0) m_slow = m_slow - 1;
      if (flt && m_fc < CMAX) m_fc = m_fc + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2/R5/R8/R9 q_out", int'(q_out), m_q);
    chk("R3/R8/R9 err_out", int'(err_out), m_err);
    chk("R4 flush_req", int'(flush_req), m_err);
    chk("R6 slow_req", int'(slow_req), (m_slow > 0) ? 1 : 0);
    chk("R7 fault_cnt", int'(fault_cnt), m_fc);
  endtask

  // compare after the previous edge, then drive the inputs for the next edge
  task automatic step(input logic stb, input int d, input int k, input int sl);
    @(negedge clk);
    compare_all();
    main_stb = stb; d_in = W'(d); shadow_ticks = DW'(k); slow_len = SW'(sl);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; main_stb = 1'b0; d_in = '0; shadow_ticks = '0; slow_len = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 q_out", int'(q_out), 0);
    chk("R1 err_out", int'(err_out), 0);
    chk("R1 slow_req", int'(slow_req), 0);
    chk("R1 fault_cnt", int'(fault_cnt), 0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0);
    // R2/R9: stable data, shadow at 3 edges, no fault
    step(1, 8'h5A, 3, 5); step(0, 8'h5A, 3, 5); step(0, 8'h5A, 3, 5);
    step(0, 8'h5A, 3, 5); step(0, 8'h13, 0, 5); step(0, 8'h27, 0, 5); // R9: window closed
    // R3/R5/R6: late change caught at the 2nd edge
    step(1, 8'h11, 2, 5); step(0, 8'h22, 2, 5);
    for (int i = 0; i < 8; i++) step(0, 8'h22, 2, 5);
    // R3: ticks = 0 treated as 1
    step(1, 8'h30, 0, 0); step(0, 8'h31, 0, 0); step(0, 8'h31, 0, 0); step(0, 8'h31, 0, 0);
    // R8: restart before the shadow edge
    step(1, 8'h40, 4, 3); step(0, 8'h40, 4, 3); step(1, 8'h41, 4, 3);
    step(0, 8'h41, 4, 3); step(0, 8'h41, 4, 3); step(0, 8'h41, 4, 3);
    step(0, 8'h41, 4, 3); step(0, 8'h41, 4, 3);
    // R6: fault during slow mode reloads; long window of 7
    step(1, 8'h50, 1, 9); step(0, 8'h51, 1, 9); step(0, 8'h51, 1, 9);
    step(1, 8'h60, 7, 9);
    for (int i = 0; i < 6; i++) step(0, 8'h60, 7, 9);
    step(0, 8'h61, 7, 9);
    for (int i = 0; i < 12; i++) step(0, 8'h61, 7, 9);
    // R7: drive faults until the counter saturates
    for (int i = 0; i < 12; i++) begin
      step(1, i, 1, 2); step(0, i + 100, 1, 2); step(0, i + 100, 1, 2);
    end
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk("R7 saturation", int'(fault_cnt), CMAX);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic s;
      int dv;
      s  = ($urandom_range(0, 3) == 0);
      dv = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 255)) : int'(d_in);
      step(s, dv, int'($urandom_range(0, 7)), int'($urandom_range(0, 15)));
    end
    // reset again in mid-traffic: R1
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 fault_cnt after reset", int'(fault_cnt), 0);
    chk("R1 q_out after reset", int'(q_out), 0);
    rst_n = 1'b1; main_stb = 1'b0;
    repeat (2) step(0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule